// File: doc/BRIEF.md
# Differential Clock Output Mode and Power-State Controller

This controller sits beside the analog PLL and output drivers of a differential clock generator and tells the output path what to do. It runs on a free-running control clock. Two active-low pins, power-down and clock-stop, select one of three power states. Power-down always takes priority. A three-bit operating-mode code picks the clock sent to the pair: the phase-aligned clock, the PLL clock or the reference clock. The code can also float the pair. The controller reports the choice as a source select plus separate tri-state and drive-low controls.

The mode code is configuration. It is taken in only while the block is powered down, and any attempt to change it at another time is flagged and has no effect. A two-bit multiplier select is turned into a feedback/prescaler divider pair for the PLL. This select may also change while running, which restarts a settle timer. The block also times the output's return from a stop. The phase counts as restored only after a set number of output-clock cycles, counted through a per-cycle tick input. The block raises a sticky flag when a stop lasted too long, or when it came too soon after the previous re-enable.

All inputs are plain level control pins sampled on the control clock; no data stream passes through the block, so there is no valid/ready handshake.

Top module: `clkgen_mode_ctrl`

## Requirements
- R1: The registered power state (pwr_state) follows the pins one control-clock edge later. It is 0 (powered down) whenever pdn_n is low, whatever stop_n is. It is 1 (clock off) when pdn_n is high and stop_n is low. It is 2 (running) when both pins are high.
- R2: In state 0, out_low is 1 and out_hiz is 0. In state 1, out_hiz is 1 and out_low is 0. In both states src_sel is 0 (no source). At most one of out_hiz, out_low and a nonzero src_sel is active.
- R3: In state 2 the output follows the latched mode code. Code 000 gives src_sel 1 (aligned clock). Code 100 gives src_sel 2 (PLL clock). Code 110 gives src_sel 3 (reference clock). Codes 010 and 011 give out_hiz 1 with src_sel 0. out_low is 0 in state 2.
- R4: Codes 001, 101 and 111 (vendor test and reserved) float the outputs in state 2 as out_hiz 1 with src_sel 0. mode_err is 1 whenever the latched code is one of these three, in any state.
- R5: mode_sel is latched on every edge where pwr_state is 0, and at no other time. If mode_sel differs from the latched code on an edge outside state 0, the latched code is kept and the sticky mode_ignored flag is set. mode_ignored is cleared on an edge in state 0.
- R6: The latched multiplier select sets fb_div/pre_div as follows: 00 gives 9/2, 01 gives 6/1, 10 gives 16/3 and 11 gives 8/1. The select is latched on edges in states 0 and 2, and held in state 1.
- R7: mult_settled is 0 in state 0. Every edge in state 0, and every edge in state 2 that sees a new multiplier select, reloads a settle count of MULT_SETTLE_CYC. Otherwise the count drops by one per edge. mult_settled is 1 once the count reaches 0 outside state 0.
- R8: phase_settled is 1 only in state 2. It rises after PH_SETTLE_TICKS edges in state 2 have sampled out_clk_tick high; any time outside state 2 restarts this count.
- R9: The sticky phase_lost flag sets when state 1 has lasted more than STOP_MAX_CYC control cycles. A shorter stop leaves it clear. phase_lost is cleared on an edge in state 0.
- R10: phase_lost also sets when a run in state 2 that began from state 1 lasts fewer than ON_MIN_CYC cycles before state 1 is entered again. A run of state 2 entered from state 0 is exempt.
- R11: An asynchronous low on rst_n forces state 0. It also resets the latched mode to 000 and the multiplier select to 00 (fb_div 9, pre_div 2), and clears mode_ignored, phase_lost, mult_settled and phase_settled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pdn_n | input | 1 | Power-down request, active low, highest priority |
| stop_n | input | 1 | Clock-stop request, active low |
| mode_sel | input | 3 | Operating-mode code |
| mult_sel | input | 2 | Multiplier select |
| out_clk_tick | input | 1 | One-cycle pulse per output clock cycle |
| src_sel | output | 2 | Output source: 0 none, 1 aligned, 2 PLL, 3 reference |
| out_hiz | output | 1 | Float the output pair |
| out_low | output | 1 | Drive both outputs low |
| fb_div | output | 5 | PLL feedback divider |
| pre_div | output | 2 | PLL prescaler divider |
| pwr_state | output | 2 | 0 powered down, 1 clock off, 2 running |
| phase_settled | output | 1 | Output phase restored after re-enable |
| mult_settled | output | 1 | Multiplier settle window expired |
| phase_lost | output | 1 | Sticky: stop too long or re-stopped too soon |
| mode_ignored | output | 1 | Sticky: mode change attempted outside power-down |
| mode_err | output | 1 | Latched mode is a vendor-test or reserved code |

## Verification
The hardest situations to reach are the timing flags. A run in state 2 that follows a stop has to end just below or just above the minimum-on window, and a stop has to last just under or just over the maximum. Random pin toggling almost never lands near those borders. Directed sequences place the pin edges a few cycles on each side of each limit, and prove the exemption for a run entered from power-down. A fixed-seed random phase then toggles the pins and codes freely, and every cycle it compares the state, output decode, latched mode and divider values against a bench model.

// File: rtl/clkgen_pkg.sv
package clkgen_pkg;

  localparam int FB_W   = 5;
  localparam int PRE_W  = 2;
  localparam int MODE_W = 3;
  localparam int MULT_W = 2;

  typedef enum logic [1:0] {
    PS_DOWN = 2'd0,
    PS_OFF  = 2'd1,
    PS_RUN  = 2'd2
  } pstate_t;

  typedef enum logic [1:0] {
    SRC_NONE    = 2'd0,
    SRC_ALIGNED = 2'd1,
    SRC_PLL     = 2'd2,
    SRC_REF     = 2'd3
  } src_t;

  typedef struct packed {
    logic [FB_W-1:0]  fb;
    logic [PRE_W-1:0] pre;
  } div_pair_t;

  typedef struct packed {
    src_t src;
    logic hiz;
    logic err;
  } mode_dec_t;

  function automatic div_pair_t mult_to_div(input logic [MULT_W-1:0] m);
    div_pair_t d;
    case (m)
      2'b00:   begin d.fb = FB_W'(9);  d.pre = PRE_W'(2); end
      2'b01:   begin d.fb = FB_W'(6);  d.pre = PRE_W'(1); end
      2'b10:   begin d.fb = FB_W'(16); d.pre = PRE_W'(3); end
      default: begin d.fb = FB_W'(8);  d.pre = PRE_W'(1); end
    endcase
    return d;
  endfunction

  function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] c);
    mode_dec_t r;
    r.src = SRC_NONE;
    r.hiz = 1'b1;
    r.err = 1'b0;
    case (c)
      3'b000:        begin r.src = SRC_ALIGNED; r.hiz = 1'b0; end
      3'b100:        begin r.src = SRC_PLL;     r.hiz = 1'b0; end
      3'b110:        begin r.src = SRC_REF;     r.hiz = 1'b0; end
      3'b010, 3'b011: r.hiz = 1'b1;
      default:       r.err = 1'b1;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/clkgen_pwr_fsm.sv
module clkgen_pwr_fsm
  import clkgen_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    pdn_n,
  input  logic    stop_n,
  output pstate_t state_q,
  output pstate_t state_d
);

  always_comb begin
    if (!pdn_n)       state_d = PS_DOWN;
    else if (!stop_n) state_d = PS_OFF;
    else              state_d = PS_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_DOWN;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/clkgen_cfg_latch.sv
module clkgen_cfg_latch
  import clkgen_pkg::*;
#(
  parameter int MULT_SETTLE_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pstate_t           state_q,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic [MULT_W-1:0] mult_sel,
  output logic [MODE_W-1:0] mode_q,
  output div_pair_t         div,
  output logic              mode_ignored,
  output logic              mult_settled
);

  localparam int CW = $clog2(MULT_SETTLE_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(MULT_SETTLE_CYC);

  logic [MULT_W-1:0] mult_q;
  logic [CW-1:0]     cnt_q;
  logic              mult_new;
  logic              in_down;

  assign in_down  = (state_q == PS_DOWN);
  assign mult_new = (state_q == PS_RUN) && (mult_sel != mult_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q       <= '0;
      mode_ignored <= 1'b0;
    end else if (in_down) begin
      mode_q       <= mode_sel;
      mode_ignored <= 1'b0;
    end else if (mode_sel != mode_q) begin
      mode_ignored <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                mult_q <= '0;
    else if (state_q != PS_OFF) mult_q <= mult_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  cnt_q <= RELOAD;
    else if (in_down || mult_new) cnt_q <= RELOAD;
    else if (cnt_q != '0)         cnt_q <= cnt_q - 1'b1;
  end

  assign div          = mult_to_div(mult_q);
  assign mult_settled = !in_down && (cnt_q == '0);

endmodule

// File: rtl/clkgen_stop_timers.sv
module clkgen_stop_timers
  import clkgen_pkg::*;
#(
  parameter int STOP_MAX_CYC    = 25000,
  parameter int ON_MIN_CYC      = 25,
  parameter int PH_SETTLE_TICKS = 20
) (
  input  logic    clk,
  input  logic    rst_n,
  input  pstate_t state_q,
  input  pstate_t state_d,
  input  logic    out_clk_tick,
  output logic    phase_settled,
  output logic    phase_lost
);

  localparam int SW = $clog2(STOP_MAX_CYC + 1);
  localparam int OW = $clog2(ON_MIN_CYC + 1);
  localparam int PW = $clog2(PH_SETTLE_TICKS + 1);
  localparam logic [SW-1:0] STOP_LIM = SW'(STOP_MAX_CYC);
  localparam logic [OW-1:0] ON_LIM   = OW'(ON_MIN_CYC);
  localparam logic [OW-1:0] ON_LAST  = OW'(ON_MIN_CYC - 1);
  localparam logic [PW-1:0] PH_LIM   = PW'(PH_SETTLE_TICKS);

  logic [SW-1:0] stop_cnt_q;
  logic [OW-1:0] on_cnt_q;
  logic [PW-1:0] ph_cnt_q;
  logic          stop_overrun;
  logic          early_restop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     stop_cnt_q <= '0;
    else if (state_q != PS_OFF)     stop_cnt_q <= '0;
    else if (stop_cnt_q != STOP_LIM) stop_cnt_q <= stop_cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) on_cnt_q <= ON_LIM;
    else begin
      case (state_q)
        PS_DOWN: on_cnt_q <= ON_LIM;
        PS_OFF:  on_cnt_q <= '0;
        default: if (on_cnt_q != ON_LIM) on_cnt_q <= on_cnt_q + 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   ph_cnt_q <= PH_LIM;
    else if (state_q != PS_RUN)   ph_cnt_q <= PH_LIM;
    else if (out_clk_tick && ph_cnt_q != '0) ph_cnt_q <= ph_cnt_q - 1'b1;
  end

  assign stop_overrun = (state_q == PS_OFF) && (stop_cnt_q == STOP_LIM);
  assign early_restop = (state_q == PS_RUN) && (state_d == PS_OFF) && (on_cnt_q < ON_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           phase_lost <= 1'b0;
    else if (state_q == PS_DOWN)          phase_lost <= 1'b0;
    else if (stop_overrun || early_restop) phase_lost <= 1'b1;
  end

  assign phase_settled = (state_q == PS_RUN) && (ph_cnt_q == '0);

endmodule

// File: rtl/clkgen_out_ctrl.sv
module clkgen_out_ctrl
  import clkgen_pkg::*;
(
  input  pstate_t           state_q,
  input  logic [MODE_W-1:0] mode_q,
  output src_t              src_sel,
  output logic              out_hiz,
  output logic              out_low,
  output logic              mode_err
);

  mode_dec_t dec;

  assign dec      = decode_mode(mode_q);
  assign mode_err = dec.err;

  always_comb begin
    src_sel = SRC_NONE;
    out_hiz = 1'b0;
    out_low = 1'b0;
    case (state_q)
      PS_DOWN: out_low = 1'b1;
      PS_OFF:  out_hiz = 1'b1;
      default: begin
        out_hiz = dec.hiz;
        src_sel = dec.hiz ? SRC_NONE : dec.src;
      end
    endcase
  end

endmodule

// File: rtl/clkgen_mode_ctrl.sv
module clkgen_mode_ctrl
  import clkgen_pkg::*;
#(
  parameter int STOP_MAX_CYC    = 25000,
  parameter int ON_MIN_CYC      = 25,
  parameter int PH_SETTLE_TICKS = 20,
  parameter int MULT_SETTLE_CYC = 250000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pdn_n,
  input  logic              stop_n,
  input  logic [MODE_W-1:0] mode_sel,
  input  logic [MULT_W-1:0] mult_sel,
  input  logic              out_clk_tick,
  output logic [1:0]        src_sel,
  output logic              out_hiz,
  output logic              out_low,
  output logic [FB_W-1:0]   fb_div,
  output logic [PRE_W-1:0]  pre_div,
  output logic [1:0]        pwr_state,
  output logic              phase_settled,
  output logic              mult_settled,
  output logic              phase_lost,
  output logic              mode_ignored,
  output logic              mode_err
);

  pstate_t           st_q, st_d;
  logic [MODE_W-1:0] mode_q;
  div_pair_t         div;
  src_t              src;

  clkgen_pwr_fsm u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .pdn_n   (pdn_n),
    .stop_n  (stop_n),
    .state_q (st_q),
    .state_d (st_d)
  );

  clkgen_cfg_latch #(
    .MULT_SETTLE_CYC (MULT_SETTLE_CYC)
  ) u_cfg (
    .clk          (clk),
    .rst_n        (rst_n),
    .state_q      (st_q),
    .mode_sel     (mode_sel),
    .mult_sel     (mult_sel),
    .mode_q       (mode_q),
    .div          (div),
    .mode_ignored (mode_ignored),
    .mult_settled (mult_settled)
  );

  clkgen_stop_timers #(
    .STOP_MAX_CYC    (STOP_MAX_CYC),
    .ON_MIN_CYC      (ON_MIN_CYC),
    .PH_SETTLE_TICKS (PH_SETTLE_TICKS)
  ) u_tmr (
    .clk           (clk),
    .rst_n         (rst_n),
    .state_q       (st_q),
    .state_d       (st_d),
    .out_clk_tick  (out_clk_tick),
    .phase_settled (phase_settled),
    .phase_lost    (phase_lost)
  );

  clkgen_out_ctrl u_out (
    .state_q  (st_q),
    .mode_q   (mode_q),
    .src_sel  (src),
    .out_hiz  (out_hiz),
    .out_low  (out_low),
    .mode_err (mode_err)
  );

  assign src_sel   = src;
  assign fb_div    = div.fb;
  assign pre_div   = div.pre;
  assign pwr_state = st_q;

endmodule

// File: rtl/clkgen_mode_ctrl_chk.sv
module clkgen_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pdn_n,
  input logic [1:0] src_sel,
  input logic       out_hiz,
  input logic       out_low,
  input logic [4:0] fb_div,
  input logic [1:0] pwr_state,
  input logic       phase_settled,
  input logic       mult_settled,
  input logic       phase_lost
);

  p_pdn_priority_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_n |=> (pwr_state == 2'd0));

  p_down_drives_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0) |-> (out_low && !out_hiz && src_sel == 2'd0));

  p_off_floats_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd1) |-> (out_hiz && !out_low && src_sel == 2'd0));

  p_out_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({out_hiz, out_low, src_sel != 2'd0}));

  p_run_src_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd2) |=> (pwr_state != 2'd2 || $stable(src_sel)));

  p_div_change_unsettled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fb_div) |-> !mult_settled);

  p_settled_only_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    phase_settled |-> (pwr_state == 2'd2));

  p_down_clears_lost_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'd0) |=> !phase_lost);

endmodule

bind clkgen_mode_ctrl clkgen_mode_ctrl_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pdn_n         (pdn_n),
  .src_sel       (src_sel),
  .out_hiz       (out_hiz),
  .out_low       (out_low),
  .fb_div        (fb_div),
  .pwr_state     (pwr_state),
  .phase_settled (phase_settled),
  .mult_settled  (mult_settled),
  .phase_lost    (phase_lost)
);

// File: tb/tb_clkgen_mode_ctrl.sv
`timescale 1ns/1ps
module tb_clkgen_mode_ctrl;

  localparam int STOP_MAX = 200;
  localparam int ON_MIN   = 25;
  localparam int PH_TICKS = 20;
  localparam int MSETTLE  = 50;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       pdn_n = 1'b0;
  logic       stop_n = 1'b1;
  logic [2:0] mode_sel = 3'b000;
  logic [1:0] mult_sel = 2'b00;
  logic       out_clk_tick = 1'b0;
  logic [1:0] src_sel;
  logic       out_hiz, out_low;
  logic [4:0] fb_div;
  logic [1:0] pre_div;
  logic [1:0] pwr_state;
  logic       phase_settled, mult_settled, phase_lost, mode_ignored, mode_err;

  int errors = 0;
  int checks = 0;
  bit chk_en = 1'b0;
  bit done = 1'b0;

  int st_m = 0;
  logic [2:0] mode_m = 3'b000;
  logic [1:0] mult_m = 2'b00;
  bit ign_m = 1'b0;

  always #2 clk = ~clk;

  clkgen_mode_ctrl #(
    .STOP_MAX_CYC    (STOP_MAX),
    .ON_MIN_CYC      (ON_MIN),
    .PH_SETTLE_TICKS (PH_TICKS),
    .MULT_SETTLE_CYC (MSETTLE)
  ) dut (
    .clk (clk), .rst_n (rst_n), .pdn_n (pdn_n), .stop_n (stop_n),
    .mode_sel (mode_sel), .mult_sel (mult_sel), .out_clk_tick (out_clk_tick),
    .src_sel (src_sel), .out_hiz (out_hiz), .out_low (out_low),
    .fb_div (fb_div), .pre_div (pre_div), .pwr_state (pwr_state),
    .phase_settled (phase_settled), .mult_settled (mult_settled),
    .phase_lost (phase_lost), .mode_ignored (mode_ignored), .mode_err (mode_err)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int exp_fb(input logic [1:0] m);
    case (m) 2'b00: return 9; 2'b01: return 6; 2'b10: return 16; default: return 8; endcase
  endfunction

  function automatic int exp_pre(input logic [1:0] m);
    case (m) 2'b00: return 2; 2'b10: return 3; default: return 1; endcase
  endfunction

  function automatic int exp_src(input int st, input logic [2:0] md);
    if (st != 2) return 0;
    case (md) 3'b000: return 1; 3'b100: return 2; 3'b110: return 3; default: return 0; endcase
  endfunction

  function automatic int exp_hiz(input int st, input logic [2:0] md);
    if (st == 0) return 0;
    if (st == 1) return 1;
    return (exp_src(st, md) == 0) ? 1 : 0;
  endfunction

  function automatic int exp_err(input logic [2:0] md);
    return (md == 3'b001 || md == 3'b101 || md == 3'b111) ? 1 : 0;
  endfunction

  task automatic model_update();
    if (st_m == 0) begin
      mode_m = mode_sel;
      ign_m  = 1'b0;
    end else if (mode_sel != mode_m) begin
      ign_m = 1'b1;
    end
    if (st_m != 1) mult_m = mult_sel;
    st_m = !pdn_n ? 0 : (!stop_n ? 1 : 2);
  endtask

  task automatic check_static();
    chk("R1", "pwr_state", int'(pwr_state), st_m);
    chk("R3", "src_sel", int'(src_sel), exp_src(st_m, mode_m));
    chk("R2", "out_hiz", int'(out_hiz), exp_hiz(st_m, mode_m));
    chk("R2", "out_low", int'(out_low), (st_m == 0) ? 1 : 0);
    chk("R4", "mode_err", int'(mode_err), exp_err(mode_m));
    chk("R5", "mode_ignored", int'(mode_ignored), int'(ign_m));
    chk("R6", "fb_div", int'(fb_div), exp_fb(mult_m));
    chk("R6", "pre_div", int'(pre_div), exp_pre(mult_m));
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_update();
      @(negedge clk);
      if (chk_en) check_static();
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog R1: run hung, actual=1 expected=0");
      finish_run();
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5eed_1234);
    pdn_n = 1'b0; stop_n = 1'b1; mode_sel = 3'b000; mult_sel = 2'b01;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", "reset state", int'(pwr_state), 0);
    chk("R11", "reset out_low", int'(out_low), 1);
    chk("R11", "reset fb_div", int'(fb_div), 9);
    chk("R11", "reset pre_div", int'(pre_div), 2);
    chk("R11", "reset flags", int'({phase_lost, mode_ignored, mult_settled, phase_settled}), 0);
    rst_n = 1'b1;
    chk_en = 1'b1;
    cyc(3);
    chk("R7", "unsettled in down", int'(mult_settled), 0);

    // run from down
    pdn_n = 1'b1; stop_n = 1'b1;
    cyc(MSETTLE + 6);
    chk("R7", "settled after window", int'(mult_settled), 1);
    chk("R6", "fb after latch", int'(fb_div), 6);

    // multiplier hot change
    mult_sel = 2'b10;
    cyc(3);
    chk("R7", "restart on change", int'(mult_settled), 0);
    cyc(MSETTLE + 2);
    chk("R7", "settled again", int'(mult_settled), 1);

    // mode change while running is ignored
    mode_sel = 3'b100;
    cyc(2);
    chk("R5", "ignored flag", int'(mode_ignored), 1);
    chk("R5", "src kept aligned", int'(src_sel), 1);

    // stop, multiplier held in clock off
    stop_n = 1'b0;
    cyc(2);
    mult_sel = 2'b11;
    cyc(8);
    chk("R6", "fb held in off", int'(fb_div), 16);
    chk("R2", "off floats", int'(out_hiz), 1);

    // re-enable and phase settle count
    stop_n = 1'b1;
    cyc(1);
    out_clk_tick = 1'b1;
    cyc(PH_TICKS - 1);
    chk("R8", "not yet settled", int'(phase_settled), 0);
    cyc(1);
    out_clk_tick = 1'b0;
    chk("R8", "settled after ticks", int'(phase_settled), 1);
    cyc(ON_MIN + 10);
    chk("R10", "no lost yet", int'(phase_lost), 0);

    // short stop stays clean
    stop_n = 1'b0;
    cyc(STOP_MAX - 3);
    stop_n = 1'b1;
    cyc(3);
    chk("R9", "short stop no flag", int'(phase_lost), 0);
    chk("R8", "restart after stop", int'(phase_settled), 0);
    cyc(ON_MIN + 10);

    // long stop
    stop_n = 1'b0;
    cyc(STOP_MAX + 5);
    chk("R9", "long stop flags", int'(phase_lost), 1);

    // power down clears, mode vendor code
    pdn_n = 1'b0;
    mode_sel = 3'b101;
    cyc(3);
    chk("R9", "cleared in down", int'(phase_lost), 0);
    chk("R5", "ignored cleared", int'(mode_ignored), 0);
    pdn_n = 1'b1; stop_n = 1'b1;
    cyc(3);
    chk("R4", "vendor floats", int'(out_hiz), 1);
    chk("R4", "vendor err", int'(mode_err), 1);

    // R10: run from down is exempt
    pdn_n = 1'b0; mode_sel = 3'b000;
    cyc(2);
    pdn_n = 1'b1;
    cyc(3);
    stop_n = 1'b0;
    cyc(5);
    chk("R10", "exempt from down", int'(phase_lost), 0);
    stop_n = 1'b1;
    cyc(ON_MIN - 10);
    stop_n = 1'b0;
    cyc(3);
    chk("R10", "early restop flags", int'(phase_lost), 1);
    pdn_n = 1'b0;
    cyc(2);
    pdn_n = 1'b1; stop_n = 1'b0;
    cyc(5);
    stop_n = 1'b1;
    cyc(ON_MIN + 5);
    stop_n = 1'b0;
    cyc(3);
    chk("R10", "long enough run clean", int'(phase_lost), 0);
    stop_n = 1'b1;

    // random phase
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(0, 39) == 0) pdn_n = ~pdn_n;
      if ($urandom_range(0, 9) == 0) stop_n = ~stop_n;
      if ($urandom_range(0, 7) == 0) mode_sel = 3'($urandom_range(0, 7));
      if ($urandom_range(0, 7) == 0) mult_sel = 2'($urandom_range(0, 3));
      out_clk_tick = 1'($urandom_range(0, 1));
      cyc(1);
    end

    done = 1'b1;
    finish_run();
  end

endmodule